// File: doc/BRIEF.md
# Conversion and Calibration Sequencer

This block is the control core on the digital side of a successive-approximation converter. It times a conversion or a self-calibration by counting master clock cycles. It drives the busy flag, the hold strobe for the sampler and the enable for the conversion engine, and it raises a power-down request when the converter may sleep. The comparator and DAC are not part of the block. In their place, a stub input word is captured into the result register when a conversion ends, and into the calibration word when a calibration ends.

Three asynchronous inputs each pass through a two-flop synchronizer: convert-start, calibration and an active-low sleep request. A conversion cycle starts when convert-start goes low, which marks the converter busy. When convert-start goes back high, the sample is held and the timed conversion begins. Driving the calibration input low aborts any operation and holds the calibration control in reset. Its rising edge starts a longer timed calibration. Sleep is granted only while nothing is running. The stored calibration word and the last result are kept through sleep.

Top module: `conv_cal_seq`

## Requirements
- R1: After reset, busy_o, hold_o, conv_en_o, pwr_down_o and done_o are 0, and result_o and cal_word_o are 0.
- R2: When idle, a high-to-low change on convst_i raises busy_o while hold_o stays 0.
- R3: A low-to-high change on convst_i, idle or after R2, sets hold_o and conv_en_o high for exactly CONV_CYCLES consecutive cycles, with busy_o high throughout.
- R4: In the cycle after hold_o falls, done_o is high for exactly one cycle, busy_o is 0, and result_o holds the value stub_i had at that edge. result_o changes at no other time.
- R5: convst_i edges that arrive while busy_o is high do not change the conversion length and add no done pulse.
- R6: While the synchronized cal_i is low, busy_o, hold_o and conv_en_o are 0, no done pulse occurs, and convst_i edges start nothing. A conversion in progress is dropped.
- R7: A rising edge on cal_i sets busy_o high for exactly CAL_CYCLES cycles, with hold_o at 0. When it ends, cal_word_o loads stub_i. convst_i edges during calibration are ignored, and cal_word_o changes at no other time.
- R8: When idle, sleep_ni low sets pwr_down_o, and sleep_ni high clears it. pwr_down_o and busy_o are never high together.
- R9: A sleep request that arrives while busy is deferred. pwr_down_o rises in the cycle after busy_o falls.
- R10: While asleep, convst_i edges start nothing, and result_o and cal_word_o keep their values.
- R11: Every input change takes effect on the third rising clock edge after it, counting the two synchronizer flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convst_i | input | 1 | Convert-start, asynchronous. The falling edge marks busy and the rising edge holds and converts |
| cal_i | input | 1 | Calibration, asynchronous. Low holds calibration in reset and the rising edge starts calibration |
| sleep_ni | input | 1 | Sleep request, asynchronous, active low |
| stub_i | input | RES_W | Stand-in data word captured at the end of an operation |
| busy_o | output | 1 | An operation is running |
| hold_o | output | 1 | Sampler in hold |
| conv_en_o | output | 1 | Conversion engine enabled |
| pwr_down_o | output | 1 | Power-down granted |
| done_o | output | 1 | One-cycle pulse that loads result_o |
| result_o | output | RES_W | Last conversion result |
| cal_word_o | output | RES_W | Stored calibration word |

## Verification
The hardest case to reach is a sleep request, or a calibration reset, that lands while a conversion is in the middle of its count. The ports give no view of the internal counter. The stimulus therefore waits a fixed number of cycles after hold_o is seen high, then drops sleep_ni or cal_i. It then checks, to the exact cycle, when busy_o falls and when pwr_down_o rises, and whether a done pulse appears. Sleep and calibration requests that arrive while asleep or idle use the same counted waits.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CONV,
        ST_CAL_RST,
        ST_CAL,
        ST_SLEEP
    } seq_state_e;

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
    parameter int unsigned  W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[b] <= RST_VAL[b];
                sync_q[b] <= RST_VAL[b];
            end else begin
                meta_q[b] <= async_i[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/conv_cal_seq.sv
module conv_cal_seq
    import conv_seq_pkg::*;
#(
    parameter int unsigned CONV_CYCLES = 16,
    parameter int unsigned CAL_CYCLES  = 256,
    parameter int unsigned RES_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             convst_i,
    input  logic             cal_i,
    input  logic             sleep_ni,
    input  logic [RES_W-1:0] stub_i,
    output logic             busy_o,
    output logic             hold_o,
    output logic             conv_en_o,
    output logic             pwr_down_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o,
    output logic [RES_W-1:0] cal_word_o
);

    localparam int unsigned MAX_CYC = (CAL_CYCLES > CONV_CYCLES) ? CAL_CYCLES : CONV_CYCLES;
    localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] CAL_LOAD  = CNT_W'(CAL_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic             conv_prev;
        logic             cal_prev;
        logic             done;
        logic [RES_W-1:0] result;
        logic [RES_W-1:0] cal_word;
    } seq_regs_t;

    // synchronized inputs: [2]=convert-start, [1]=calibration, [0]=sleep_n
    logic [2:0] in_sync;
    logic       conv_lvl, cal_lvl, sleep_lvl_n;

    seq_sync #(.W(3), .RST_VAL(3'b111)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({convst_i, cal_i, sleep_ni}),
        .sync_o (in_sync)
    );

    assign conv_lvl    = in_sync[2];
    assign cal_lvl     = in_sync[1];
    assign sleep_lvl_n = in_sync[0];

    seq_regs_t r_d, r_q;
    logic             tmr_load, tmr_run, tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    seq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .run_i     (tmr_run),
        .zero_o    (tmr_zero)
    );

    logic conv_rise, conv_fall, cal_rise;
    assign conv_rise = conv_lvl  & ~r_q.conv_prev;
    assign conv_fall = ~conv_lvl &  r_q.conv_prev;
    assign cal_rise  = cal_lvl   & ~r_q.cal_prev;

    always_comb begin
        r_d           = r_q;
        r_d.conv_prev = conv_lvl;
        r_d.cal_prev  = cal_lvl;
        r_d.done      = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        tmr_run       = (r_q.state == ST_CONV) || (r_q.state == ST_CAL);

        if (!cal_lvl) begin
            // calibration input low overrides and clears all control
            r_d.state = ST_CAL_RST;
            tmr_load  = 1'b1;
            tmr_val   = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (conv_rise) begin
                        r_d.state = ST_CONV;
                        tmr_load  = 1'b1;
                        tmr_val   = CONV_LOAD;
                    end else if (conv_fall) begin
                        r_d.state = ST_ARMED;
                    end else if (!sleep_lvl_n) begin
                        r_d.state = ST_SLEEP;
                    end
                end
                ST_ARMED: begin
                    if (conv_rise) begin
                        r_d.state = ST_CONV;
                        tmr_load  = 1'b1;
                        tmr_val   = CONV_LOAD;
                    end
                end
                ST_CONV: begin
                    if (tmr_zero) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = stub_i;
                    end
                end
                ST_CAL_RST: begin
                    if (cal_rise) begin
                        r_d.state = ST_CAL;
                        tmr_load  = 1'b1;
                        tmr_val   = CAL_LOAD;
                    end
                end
                ST_CAL: begin
                    if (tmr_zero) begin
                        r_d.state    = ST_IDLE;
                        r_d.cal_word = stub_i;
                    end
                end
                ST_SLEEP: begin
                    if (sleep_lvl_n) r_d.state = ST_IDLE;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.conv_prev <= 1'b1;
            r_q.cal_prev  <= 1'b1;
            r_q.done      <= 1'b0;
            r_q.result    <= '0;
            r_q.cal_word  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.state == ST_ARMED) || (r_q.state == ST_CONV) || (r_q.state == ST_CAL);
    assign hold_o     = (r_q.state == ST_CONV);
    assign conv_en_o  = (r_q.state == ST_CONV);
    assign pwr_down_o = (r_q.state == ST_SLEEP);
    assign done_o     = r_q.done;
    assign result_o   = r_q.result;
    assign cal_word_o = r_q.cal_word;

endmodule

// File: rtl/conv_cal_seq_chk.sv
module conv_cal_seq_chk #(
    parameter int unsigned RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cal_lvl,
    input logic             busy_o,
    input logic             hold_o,
    input logic             pwr_down_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o,
    input logic [RES_W-1:0] cal_word_o
);

    // R3: hold only inside a busy period
    a_r3_hold_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> busy_o);

    // R4: done lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: done follows the end of hold, with busy already low
    a_r4_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(hold_o) && !hold_o && !busy_o));

    // R4: result moves only with done
    a_r4_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    // R6: calibration reset level clears busy on the next cycle
    a_r6_cal_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_lvl |=> (!busy_o && !done_o));

    // R7: calibration word moves only at the end of a busy period without done
    a_r7_cal_word_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cal_word_o) |-> ($fell(busy_o) && !done_o));

    // R8: never powered down while busy
    a_r8_pwr_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_o |-> !busy_o);

    // R9: no power-down in the cycle busy falls
    a_r9_sleep_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !pwr_down_o);

endmodule

bind conv_cal_seq conv_cal_seq_chk #(.RES_W(RES_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_lvl   (cal_lvl),
    .busy_o    (busy_o),
    .hold_o    (hold_o),
    .pwr_down_o(pwr_down_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .cal_word_o(cal_word_o)
);

// File: tb/test_conv_cal_seq.sv
module test_conv_cal_seq;

    localparam int CONV = 16;
    localparam int CALC = 256;
    localparam int RW   = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          convst = 1'b1;
    logic          cal = 1'b1;
    logic          sleep_n = 1'b1;
    logic [RW-1:0] stub = '0;
    logic          busy, hold, conv_en, pwr, done;
    logic [RW-1:0] result, cal_word;

    int checks = 0;
    int fails = 0;
    int done_seen = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    conv_cal_seq #(.CONV_CYCLES(CONV), .CAL_CYCLES(CALC), .RES_W(RW)) i_conv_cal_seq (
        .clk(clk), .rst_n(rst_n), .convst_i(convst), .cal_i(cal), .sleep_ni(sleep_n),
        .stub_i(stub), .busy_o(busy), .hold_o(hold), .conv_en_o(conv_en),
        .pwr_down_o(pwr), .done_o(done), .result_o(result), .cal_word_o(cal_word)
    );

    always @(negedge clk) if (done) done_seen++;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected below 100000", cyc);
            finish_run();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // row fields: [15:4] stub, [3:1] low cycles of convert-start, [0] poke convert-start mid-conversion
    localparam logic [15:0] VEC [6] = '{
        {12'hA5C, 3'd1, 1'b0},
        {12'h3F0, 3'd5, 1'b0},
        {12'hFFF, 3'd3, 1'b1},
        {12'h001, 3'd2, 1'b0},
        {12'h800, 3'd4, 1'b1},
        {12'h7FF, 3'd6, 1'b0}
    };

    task automatic run_conv(input logic [RW-1:0] s, input int low_len, input bit poke);
        int n;
        int d0;
        stub = s;
        d0 = done_seen;
        convst = 1'b0;
        tick(low_len);
        if (low_len >= 3) check(busy && !hold, "R2 busy on fall", int'({busy, hold}), 2);
        convst = 1'b1;
        tick(2);
        check(!hold, "R11 hold not yet", int'(hold), 0);
        tick(1);
        n = 0;
        while (hold && n < 1000) begin
            check(busy && conv_en, "R3 busy and enable during hold", int'({busy, conv_en}), 3);
            n++;
            if (poke && n == 4) convst = 1'b0;
            if (poke && n == 7) convst = 1'b1;
            tick(1);
        end
        check(n == CONV, "R3 hold length", n, CONV);
        check(done && !busy, "R4 done with busy low", int'({done, busy}), 2);
        check(result == s, "R4 result", int'(result), int'(s));
        tick(1);
        check(!done, "R4 done one cycle", int'(done), 0);
        check(done_seen == d0 + 1, poke ? "R5 single done" : "R4 done count", done_seen - d0, 1);
        tick(3);
        check(!busy, "R5 no restart", int'(busy), 0);
    endtask

    initial begin
        int n;
        int d0;
        logic [RW-1:0] keep_res, keep_cal;

        tick(2);
        check(!busy && !hold && !conv_en && !pwr && !done, "R1 reset outputs",
              int'({busy, hold, conv_en, pwr, done}), 0);
        check(result == 0 && cal_word == 0, "R1 reset words", int'(result), 0);
        rst_n = 1'b1;
        tick(3);

        for (int i = 0; i < 6; i++) begin
            run_conv(VEC[i][15:4], int'(VEC[i][3:1]), VEC[i][0]);
        end

        // R8 sleep when idle, with latency per R11
        sleep_n = 1'b0;
        tick(2);
        check(!pwr, "R11 sleep latency", int'(pwr), 0);
        tick(1);
        check(pwr, "R8 sleep granted", int'(pwr), 1);
        // R10 convert-start ignored while asleep
        keep_res = result;
        convst = 1'b0;
        tick(3);
        convst = 1'b1;
        tick(5);
        check(!busy && !hold && pwr, "R10 no conversion in sleep", int'({busy, hold, pwr}), 1);
        check(result == keep_res, "R10 result kept", int'(result), int'(keep_res));
        sleep_n = 1'b1;
        tick(3);
        check(!pwr && !busy, "R8 wake", int'({pwr, busy}), 0);

        // R9 sleep requested during a conversion
        stub = 12'h5A5;
        convst = 1'b0;
        tick(2);
        convst = 1'b1;
        tick(6);
        check(hold, "R9 in conversion", int'(hold), 1);
        sleep_n = 1'b0;
        n = 0;
        while (hold && n < 1000) begin
            check(!pwr, "R9 no sleep while busy", int'(pwr), 0);
            n++;
            tick(1);
        end
        check(!busy && !pwr, "R9 busy fell, no sleep yet", int'({busy, pwr}), 0);
        tick(1);
        check(pwr, "R9 sleep after busy", int'(pwr), 1);
        sleep_n = 1'b1;
        tick(4);

        // R6 calibration low aborts a conversion
        d0 = done_seen;
        stub = 12'h222;
        convst = 1'b0;
        tick(2);
        convst = 1'b1;
        tick(6);
        check(hold, "R6 conversion running", int'(hold), 1);
        cal = 1'b0;
        tick(3);
        check(!busy && !hold && !conv_en, "R6 abort", int'({busy, hold, conv_en}), 0);
        convst = 1'b0;
        tick(3);
        convst = 1'b1;
        tick(30);
        check(!busy && !hold, "R6 convert-start held off", int'({busy, hold}), 0);
        check(done_seen == d0, "R6 no done", done_seen - d0, 0);

        // R7 calibration from rising edge
        stub = 12'hC3C;
        cal = 1'b1;
        tick(2);
        check(!busy, "R11 cal latency", int'(busy), 0);
        tick(1);
        n = 0;
        while (busy && n < 2000) begin
            if (hold) check(0, "R7 hold during calibration", 1, 0);
            n++;
            if (n == 5) convst = 1'b0;
            if (n == 9) convst = 1'b1;
            tick(1);
        end
        check(n == CALC, "R7 calibration length", n, CALC);
        check(cal_word == 12'hC3C, "R7 calibration word", int'(cal_word), 'hC3C);
        tick(4);
        check(!busy && done_seen == d0, "R7 no done, no conversion", done_seen - d0, 0);

        // R10 calibration word kept through sleep
        keep_cal = cal_word;
        sleep_n = 1'b0;
        tick(10);
        sleep_n = 1'b1;
        tick(4);
        check(cal_word == keep_cal && !pwr, "R10 cal word kept", int'(cal_word), int'(keep_cal));

        run_conv(12'h0F0, 3, 1'b0);
        finish_run();
    end

endmodule